// File: doc/BRIEF.md
# SPI NOR Program and Erase Controller

This block takes page-program and erase requests for a serial NOR flash and turns each one into a short series of flash transactions. The flash layout comes from parameters: page size, pages per sector and sector count. Page and sector sizes must be powers of two. A request gives an operation type, a start address and a byte count.

The block first checks the request against the flash layout. A request that fails the check is answered at once with an error. For a request that passes, the block asks the command sequencer for a write-enable transaction. It then asks for the program or erase transaction, or for one block erase per sector. Last, it reads the status register until the busy bit clears. The erase command is chosen from the request size. Optional support for 4 KiB and 32 KiB erase commands is set by parameters. Between status reads that find the flash busy, the block waits a set number of clocks.

Every transaction goes out on a valid/ready request port. The sequencer reports the end of each transaction with a one-cycle done strobe and returns the byte it read.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0 and seq_valid is 0.
- R2: A program request (req_erase=0) with size 0 is accepted and answered with rsp_done=1 and rsp_err=0 in the next cycle, with no sequencer transaction.
- R3: A program request is answered in the next cycle with rsp_done=1 and rsp_err=1, with no sequencer transaction, in any of these cases: its size is larger than one page; its first and last bytes lie in different pages; its address plus size is larger than the device size.
- R4: An erase request (req_erase=1) is answered in the next cycle with rsp_done=1 and rsp_err=1, with no sequencer transaction, in any of these cases: its address is not on a sector boundary; its address plus size is larger than the device size; it falls to the per-sector case (R8) and its size is not a multiple of the sector size.
- R5: An accepted request first issues opcode 0x06 with no address and no data. A program request then issues opcode 0x02 with seq_use_addr=1, the request address, and seq_wlen equal to the request size.
- R6: An erase whose size equals the whole device issues opcode 0xC7 with seq_use_addr=0.
- R7: Other erase sizes are handled in this order. A size of 4096 issues opcode 0x20 at the request address when HAS_ERASE_4K=1. Failing that, a size of 32768 issues opcode 0x52 when HAS_ERASE_32K=1.
- R8: Any remaining erase issues opcode 0xD8 once per sector. The first address is the request address, and each later address is one sector size higher. Write enable is issued once, before the first sector, and no status read comes between sectors.
- R9: After the last command, the block reads status with opcode 0x05 and seq_rd_status=1. It ends with rsp_done=1 and rsp_err=0 when bit 0 of seq_rdata is 0; the other bits are ignored. While bit 0 is 1, it waits POLL_WAIT_CYC clocks and reads status again.
- R10: While seq_valid=1 and seq_ready=0, the request stays asserted and its opcode and address do not change.
- R11: rsp_done lasts one cycle, and req_ready is 1 only while no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle; a request is taken when both are high |
| req_erase | input | 1 | 1 = erase, 0 = page program |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | ADDR_W | Byte count |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Request rejected; valid while rsp_done is 1 |
| seq_valid | output | 1 | Transaction request to the sequencer |
| seq_ready | input | 1 | Sequencer takes the request |
| seq_opcode | output | 8 | Command opcode |
| seq_use_addr | output | 1 | Send seq_addr after the opcode |
| seq_addr | output | ADDR_W | Transaction address |
| seq_wlen | output | ADDR_W | Number of data bytes to write after the address |
| seq_rd_status | output | 1 | Read back one status byte |
| seq_done | input | 1 | Transaction finished strobe |
| seq_rdata | input | 8 | Byte read back, valid while seq_done is 1 |

## Verification
The assertions assume the sequencer follows its handshake. It raises seq_done once for each transaction it has taken, only after taking it. The returned byte must be known whenever a status read finishes. The bench's sequencer model meets these rules. It holds ready low for one cycle after it sees a request, takes the request, and answers a few cycles later with a single done pulse. It sends new requests only while req_ready is high, and it clears req_valid right after the request is taken.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam logic [7:0] OPC_WREN    = 8'h06;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_RDSR    = 8'h05;
    localparam logic [7:0] OPC_ERS_4K  = 8'h20;
    localparam logic [7:0] OPC_ERS_32K = 8'h52;
    localparam logic [7:0] OPC_ERS_BLK = 8'hD8;
    localparam logic [7:0] OPC_ERS_ALL = 8'hC7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN_RQ,
        ST_WREN_WT,
        ST_CMD_RQ,
        ST_CMD_WT,
        ST_POLL_RQ,
        ST_POLL_WT,
        ST_DELAY
    } fpe_state_t;

    function automatic bit is_pow2(input longint unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fpe_validate.sv
module fpe_validate #(
    parameter int ADDR_W        = 24,
    parameter int PAGE_BYTES    = 256,
    parameter int SECT_BYTES    = 4096,
    parameter int TOTAL_BYTES   = 65536,
    parameter int CNT_W         = 5,
    parameter bit HAS_ERASE_4K  = 1'b1,
    parameter bit HAS_ERASE_32K = 1'b1
) (
    input  logic              is_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] size,
    output logic              bad,
    output logic              noop,
    output logic [7:0]        opcode,
    output logic              use_addr,
    output logic [ADDR_W-1:0] wlen,
    output logic [CNT_W-1:0]  reps
);
    import fpe_pkg::*;

    localparam int PSH = $clog2(PAGE_BYTES);
    localparam int SSH = $clog2(SECT_BYTES);

    logic [ADDR_W:0]   end_x;
    logic [ADDR_W-1:0] first_pg;
    logic [ADDR_W-1:0] last_pg;
    logic              past_end;

    always_comb begin
        end_x    = {1'b0, addr} + {1'b0, size};
        first_pg = addr >> PSH;
        last_pg  = (addr + size - 1'b1) >> PSH;
        past_end = end_x > (ADDR_W+1)'(TOTAL_BYTES);

        bad      = 1'b0;
        noop     = 1'b0;
        opcode   = OPC_PROG;
        use_addr = 1'b1;
        wlen     = '0;
        reps     = CNT_W'(1);

        if (!is_erase) begin
            wlen = size;
            if (size == '0)
                noop = 1'b1;
            else if (size > ADDR_W'(PAGE_BYTES) || first_pg != last_pg || past_end)
                bad = 1'b1;
        end else if (addr[SSH-1:0] != '0 || past_end) begin
            bad = 1'b1;
        end else if (size == ADDR_W'(TOTAL_BYTES)) begin
            opcode   = OPC_ERS_ALL;
            use_addr = 1'b0;
        end else if (HAS_ERASE_4K && size == ADDR_W'(4096)) begin
            opcode = OPC_ERS_4K;
        end else if (HAS_ERASE_32K && size == ADDR_W'(32768)) begin
            opcode = OPC_ERS_32K;
        end else begin
            opcode = OPC_ERS_BLK;
            reps   = CNT_W'(size >> SSH);
            bad    = size[SSH-1:0] != '0;
        end
    end

endmodule

// File: rtl/fpe_wait_timer.sv
module fpe_wait_timer #(
    parameter int CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(CYC - 1));

    a_r9_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < CW'(CYC));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
    parameter int ADDR_W           = 24,
    parameter int PAGE_BYTES       = 256,
    parameter int PAGES_PER_SECTOR = 16,
    parameter int SECTOR_COUNT     = 16,
    parameter bit HAS_ERASE_4K     = 1'b1,
    parameter bit HAS_ERASE_32K    = 1'b1,
    parameter int POLL_WAIT_CYC    = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_size,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              seq_valid,
    input  logic              seq_ready,
    output logic [7:0]        seq_opcode,
    output logic              seq_use_addr,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] seq_wlen,
    output logic              seq_rd_status,
    input  logic              seq_done,
    input  logic [7:0]        seq_rdata
);
    import fpe_pkg::*;

    localparam int SECT_BYTES  = PAGE_BYTES * PAGES_PER_SECTOR;
    localparam int TOTAL_BYTES = SECT_BYTES * SECTOR_COUNT;
    localparam int SSH         = $clog2(SECT_BYTES);
    localparam int CNT_W       = $clog2(SECTOR_COUNT + 1);

    initial begin
        if (!is_pow2(PAGE_BYTES) || !is_pow2(SECT_BYTES))
            $error("page and sector sizes must be powers of two");
    end

    fpe_state_t        state;
    logic [7:0]        cur_op;
    logic              cur_use_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] cur_wlen;
    logic [CNT_W-1:0]  reps_left;

    logic              v_bad, v_noop, v_use_addr;
    logic [7:0]        v_opcode;
    logic [ADDR_W-1:0] v_wlen;
    logic [CNT_W-1:0]  v_reps;
    logic              wait_over;

    fpe_validate #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SECT_BYTES(SECT_BYTES),
        .TOTAL_BYTES(TOTAL_BYTES), .CNT_W(CNT_W),
        .HAS_ERASE_4K(HAS_ERASE_4K), .HAS_ERASE_32K(HAS_ERASE_32K)
    ) u_check (
        .is_erase(req_erase), .addr(req_addr), .size(req_size),
        .bad(v_bad), .noop(v_noop), .opcode(v_opcode), .use_addr(v_use_addr),
        .wlen(v_wlen), .reps(v_reps)
    );

    fpe_wait_timer #(.CYC(POLL_WAIT_CYC)) u_wait (
        .clk(clk), .rst(rst), .run(state == ST_DELAY), .expired(wait_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            rsp_done     <= 1'b0;
            rsp_err      <= 1'b0;
            cur_op       <= '0;
            cur_use_addr <= 1'b0;
            cur_addr     <= '0;
            cur_wlen     <= '0;
            reps_left    <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    if (v_bad || v_noop) begin
                        rsp_done <= 1'b1;
                        rsp_err  <= v_bad;
                    end else begin
                        cur_op       <= v_opcode;
                        cur_use_addr <= v_use_addr;
                        cur_addr     <= req_addr;
                        cur_wlen     <= v_wlen;
                        reps_left    <= v_reps;
                        state        <= ST_WREN_RQ;
                    end
                end
                ST_WREN_RQ: if (seq_ready) state <= ST_WREN_WT;
                ST_WREN_WT: if (seq_done)
                    state <= (reps_left == '0) ? ST_POLL_RQ : ST_CMD_RQ;
                ST_CMD_RQ:  if (seq_ready) state <= ST_CMD_WT;
                ST_CMD_WT: if (seq_done) begin
                    if (reps_left > CNT_W'(1)) begin
                        reps_left <= reps_left - 1'b1;
                        cur_addr  <= cur_addr + ADDR_W'(SECT_BYTES);
                        state     <= ST_CMD_RQ;
                    end else begin
                        state <= ST_POLL_RQ;
                    end
                end
                ST_POLL_RQ: if (seq_ready) state <= ST_POLL_WT;
                ST_POLL_WT: if (seq_done) begin
                    if (seq_rdata[0]) begin
                        state <= ST_DELAY;
                    end else begin
                        state    <= ST_IDLE;
                        rsp_done <= 1'b1;
                        rsp_err  <= 1'b0;
                    end
                end
                ST_DELAY: if (wait_over) state <= ST_POLL_RQ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = state == ST_IDLE;
        seq_valid     = state == ST_WREN_RQ || state == ST_CMD_RQ || state == ST_POLL_RQ;
        seq_use_addr  = state == ST_CMD_RQ && cur_use_addr;
        seq_addr      = (state == ST_CMD_RQ) ? cur_addr : '0;
        seq_wlen      = (state == ST_CMD_RQ) ? cur_wlen : '0;
        seq_rd_status = state == ST_POLL_RQ;
        case (state)
            ST_WREN_RQ: seq_opcode = OPC_WREN;
            ST_CMD_RQ:  seq_opcode = cur_op;
            ST_POLL_RQ: seq_opcode = OPC_RDSR;
            default:    seq_opcode = 8'h00;
        endcase
    end

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        seq_valid && !seq_ready |=> seq_valid && $stable(seq_opcode) && $stable(seq_addr));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r3_prog_len: assert property (@(posedge clk) disable iff (rst)
        seq_valid && seq_opcode == OPC_PROG |->
            seq_wlen != '0 && seq_wlen <= ADDR_W'(PAGE_BYTES));

    a_r4_erase_aligned: assert property (@(posedge clk) disable iff (rst)
        seq_valid && seq_use_addr && seq_opcode != OPC_PROG |-> seq_addr[SSH-1:0] == '0);

    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        seq_valid && seq_use_addr |-> seq_addr < ADDR_W'(TOTAL_BYTES));

    a_r9_status_known: assert property (@(posedge clk) disable iff (rst)
        state == ST_POLL_WT && seq_done |-> !$isunknown(seq_rdata));

endmodule

// File: tb/flash_pe_ctrl_tb_top.sv
module flash_pe_ctrl_tb_top;
    localparam int AW = 24;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0, req_size = '0;
    logic          req_ready, rsp_done, rsp_err;
    logic          seq_valid, seq_use_addr, seq_rd_status;
    logic          seq_ready = 1'b0, seq_done = 1'b0;
    logic [7:0]    seq_opcode, seq_rdata = 8'h00;
    logic [AW-1:0] seq_addr, seq_wlen;

    always #10 clk = ~clk;

    flash_pe_ctrl #(.ADDR_W(AW), .POLL_WAIT_CYC(PW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_addr(req_addr), .req_size(req_size),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .seq_valid(seq_valid),
        .seq_ready(seq_ready), .seq_opcode(seq_opcode), .seq_use_addr(seq_use_addr),
        .seq_addr(seq_addr), .seq_wlen(seq_wlen), .seq_rd_status(seq_rd_status),
        .seq_done(seq_done), .seq_rdata(seq_rdata)
    );

    int checks = 0, errors = 0, cyc = 0;
    int lg_n = 0, busy_left = 0, last_done = -1, min_gap = 0, max_gap = 0;
    int unstable = 0, rd_flag_bad = 0;
    logic [7:0]    lg_op   [0:31];
    logic          lg_ua   [0:31];
    logic [AW-1:0] lg_addr [0:31];
    logic [AW-1:0] lg_wlen [0:31];
    logic          got_done, got_err, pulse_ok;
    int            lat;

    initial forever begin @(posedge clk); cyc++; end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish act=hung exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // sequencer model
    initial forever begin
        @(negedge clk);
        if (seq_valid) begin
            logic [7:0] op;
            op = seq_opcode;
            if (lg_n < 32) begin
                lg_op[lg_n] = op; lg_ua[lg_n] = seq_use_addr;
                lg_addr[lg_n] = seq_addr; lg_wlen[lg_n] = seq_wlen;
            end
            lg_n++;
            if ((op == 8'h05) != seq_rd_status) rd_flag_bad++;
            if (op == 8'h05 && last_done >= 0) begin
                if (min_gap == 0 || cyc - last_done < min_gap) min_gap = cyc - last_done;
                if (cyc - last_done > max_gap) max_gap = cyc - last_done;
            end
            @(negedge clk);
            if (!seq_valid || seq_opcode != op) unstable++;
            seq_ready = 1'b1;
            @(negedge clk);
            seq_ready = 1'b0;
            repeat (2) @(negedge clk);
            if (op == 8'h05) begin
                seq_rdata = (busy_left > 0) ? 8'h01 : 8'hFE;
                if (busy_left > 0) busy_left--;
                last_done = cyc;
            end else begin
                seq_rdata = 8'h00;
            end
            seq_done = 1'b1;
            @(negedge clk);
            seq_done = 1'b0;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic er, input logic [AW-1:0] a,
                          input logic [AW-1:0] s, input int busy);
        lg_n = 0; busy_left = busy; last_done = -1; min_gap = 0; max_gap = 0;
        @(negedge clk);
        chk("R11 ready when idle", req_ready, 1);
        req_erase = er; req_addr = a; req_size = s; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; got_err = 1'b0; lat = 0;
        for (int i = 0; i < 5000 && !got_done; i++) begin
            if (rsp_done) begin got_done = 1'b1; got_err = rsp_err; end
            else begin @(negedge clk); lat++; end
        end
        @(negedge clk);
        pulse_ok = !rsp_done;
        chk("R11 done seen", got_done, 1);
        chk("R11 done single cycle", pulse_ok, 1);
    endtask

    task automatic chk_cmd(input string tag, input int i, input logic [7:0] op,
                           input logic ua, input logic [AW-1:0] a, input logic [AW-1:0] wl);
        chk({tag, " opcode"}, lg_op[i], op);
        chk({tag, " use_addr"}, lg_ua[i], ua);
        if (ua) chk({tag, " addr"}, lg_addr[i], a);
        chk({tag, " wlen"}, lg_wlen[i], wl);
    endtask

    task automatic t_reject(input string tag, input logic er,
                            input logic [AW-1:0] a, input logic [AW-1:0] s);
        do_req(er, a, s, 0);
        chk({tag, " err"}, got_err, 1);
        chk({tag, " immediate"}, lat, 0);
        chk({tag, " no traffic"}, lg_n, 0);
    endtask

    task automatic t_reset;
        chk("R1 ready", req_ready, 1);
        chk("R1 done", rsp_done, 0);
        chk("R1 seq_valid", seq_valid, 0);
    endtask

    task automatic t_prog_zero;
        do_req(1'b0, 24'h000300, 24'd0, 0);
        chk("R2 err", got_err, 0);
        chk("R2 immediate", lat, 0);
        chk("R2 no traffic", lg_n, 0);
    endtask

    task automatic t_prog_ok(input logic [AW-1:0] a, input logic [AW-1:0] s);
        do_req(1'b0, a, s, 0);
        chk("R5 err", got_err, 0);
        chk("R5 count", lg_n, 3);
        chk_cmd("R5 wren", 0, 8'h06, 1'b0, '0, '0);
        chk_cmd("R5 program", 1, 8'h02, 1'b1, a, s);
        chk_cmd("R9 status", 2, 8'h05, 1'b0, '0, '0);
    endtask

    task automatic t_erase_single(input string tag, input logic [AW-1:0] a,
                                  input logic [AW-1:0] s, input logic [7:0] op, input logic ua);
        do_req(1'b1, a, s, 0);
        chk({tag, " err"}, got_err, 0);
        chk({tag, " count"}, lg_n, 3);
        chk_cmd({tag, " wren"}, 0, 8'h06, 1'b0, '0, '0);
        chk_cmd(tag, 1, op, ua, a, '0);
        chk_cmd({tag, " status"}, 2, 8'h05, 1'b0, '0, '0);
    endtask

    task automatic t_erase_loop;
        do_req(1'b1, 24'h002000, 24'd8192, 0);
        chk("R8 err", got_err, 0);
        chk("R8 count", lg_n, 4);
        chk_cmd("R8 wren once", 0, 8'h06, 1'b0, '0, '0);
        chk_cmd("R8 sector0", 1, 8'hD8, 1'b1, 24'h002000, '0);
        chk_cmd("R8 sector1", 2, 8'hD8, 1'b1, 24'h003000, '0);
        chk_cmd("R8 status last", 3, 8'h05, 1'b0, '0, '0);
    endtask

    task automatic t_poll_busy;
        do_req(1'b0, 24'h000400, 24'd4, 3);
        chk("R9 err", got_err, 0);
        chk("R9 count", lg_n, 6);
        for (int i = 2; i < 6; i++) chk("R9 repeat status", lg_op[i], 8'h05);
        chk("R9 min gap", (min_gap >= PW) ? 1 : 0, 1);
        chk("R9 max gap", (max_gap <= PW + 2) ? 1 : 0, 1);
        chk("R9 rd_status flag", rd_flag_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_prog_zero();
        t_prog_ok(24'h000100, 24'd16);
        t_prog_ok(24'h0001F0, 24'd16);
        t_reject("R3 too long", 1'b0, 24'h000000, 24'd257);
        t_reject("R3 page cross", 1'b0, 24'h0001F0, 24'd32);
        t_reject("R3 past end", 1'b0, 24'h010000, 24'd1);
        t_reject("R4 misaligned", 1'b1, 24'h000800, 24'd4096);
        t_reject("R4 past end", 1'b1, 24'h00F000, 24'd8192);
        t_reject("R4 not multiple", 1'b1, 24'h000000, 24'd6000);
        t_erase_single("R6 chip", 24'h000000, 24'd65536, 8'hC7, 1'b0);
        t_erase_single("R7 4k", 24'h003000, 24'd4096, 8'h20, 1'b1);
        t_erase_single("R7 32k", 24'h008000, 24'd32768, 8'h52, 1'b1);
        t_erase_loop();
        t_poll_busy();
        chk("R10 request stable while not ready", unstable, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule